// File: doc/BRIEF.md
# Quad-Channel Double-Buffered DAC Register Front End

This block sits between a parallel host bus and four digital-to-analog converters. The host selects the block with an active-low chip select and puts a channel number on two address lines and a code on the data bus. It then pulses an active-low write strobe. When that strobe returns high, the code is latched into the staging register of the addressed channel. Each channel also has a second register that holds the code the converter actually sees. An active-low load strobe copies every staging register into its converter register at once, so several outputs can change together.

Load is level-sensitive: while it is held low, each converter register follows its staging register. A write made while load is low therefore reaches the output on the same clock edge. An asynchronous active-low clear zeroes both register stages of every channel and wins over any write or load at the same time. A power-on reset does the same. A power-down request is passed through to the analog stage and leaves the registers alone. The code width is a parameter and is meant for 8-, 10- and 12-bit converters.

All bus inputs are sampled on the block clock. The write strobe's rising edge is found by comparing its level at a clock edge with its level at the previous clock edge.

Top module: `dacif_quad`

## Requirements
- R1: After `rst_n` is released, every field of `dac_out` reads zero, and it stays zero until a write is followed by a load.
- R2: A write is taken at the first clock edge where `wr_n` is sampled high after having been sampled low at the previous edge, provided `cs_n` is sampled low at that edge. `data` and `addr` are sampled at that same edge.
- R3: A write strobe given while `cs_n` is high changes no staging register. A load that follows leaves `dac_out` unchanged.
- R4: `addr` value i selects channel i, and channel i appears on `dac_out[i*DATA_W +: DATA_W]`. A write changes only the addressed channel.
- R5: At a clock edge where `ld_n` is sampled low, every converter register takes its staging value. While `ld_n` stays high, `dac_out` holds.
- R6: A write taken while `ld_n` is low appears on `dac_out` at the same clock edge that accepts the write.
- R7: `clr_n` low zeroes `dac_out` at once, without waiting for a clock edge, and also zeroes the staging registers. A load after the clear is released therefore still gives zeros.
- R8: When `clr_n` is low at an edge that would accept a write with `ld_n` low, all outputs are zero and the write is lost.
- R9: `pd_out` follows `pd_in` combinationally, and asserting `pd_in` does not change `dac_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; data taken on its rising edge |
| ld_n | input | 1 | Load strobe, active low, level-sensitive |
| clr_n | input | 1 | Asynchronous clear of both stages, active low |
| addr | input | ADDR_W (2) | Channel number |
| data | input | DATA_W (10) | Code to write |
| pd_in | input | 1 | Power-down request |
| dac_out | output | NUM_CH*DATA_W (40) | Converter register codes, channel 0 in the low bits |
| pd_out | output | 1 | Power-down flag for the analog stage |

## Verification
- A write is due on `dac_out` at the clock edge that samples `wr_n` back high, if load is low at that edge. Otherwise it shows at the first edge that samples `ld_n` low.
- Each task drives its inputs on the falling clock edge and reads the outputs on a later falling edge, so every result is read half a period after the edge that produced it.
- The clear and the power-down flag do not wait for a clock. Their checks are taken a short delay after the input changes, well before the next rising edge.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
   // level seen on the write strobe at the previous clock edge
   typedef enum logic {
      STB_HIGH = 1'b0,
      STB_LOW  = 1'b1
   } stb_state_e;

   function automatic bit width_ok(input int w);
      return (w >= 1) && (w <= 16);
   endfunction
endpackage

// File: rtl/dacif_strobe.sv
module dacif_strobe
   import dacif_pkg::*;
(
   input  logic clk,
   input  logic arst_n,
   input  logic wr_n,
   output logic rise
);
   stb_state_e state_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) state_q <= STB_HIGH;
      else         state_q <= wr_n ? STB_HIGH : STB_LOW;
   end

   // strobe back high after having been low
   assign rise = (state_q == STB_LOW) && wr_n;
endmodule

// File: rtl/dacif_decode.sv
module dacif_decode #(
   parameter int NUM_CH = 4,
   localparam int ADDR_W = $clog2(NUM_CH)
) (
   input  logic              stb,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] wr_en
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      localparam logic [ADDR_W-1:0] SEL = ADDR_W'(i);
      assign wr_en[i] = stb && !cs_n && (addr == SEL);
   end
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              wr_en,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] stage_q;
   logic [DATA_W-1:0] stage_d;
   logic [DATA_W-1:0] conv_q;

   assign stage_d = wr_en ? din : stage_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         stage_q <= '0;
         conv_q  <= '0;
      end else begin
         stage_q <= stage_d;
         // transparent load: the new stage value passes straight through
         if (!ld_n) conv_q <= stage_d;
      end
   end

   assign dout = conv_q;
endmodule

// File: rtl/dacif_quad.sv
module dacif_quad #(
   parameter int DATA_W = 10,
   parameter int NUM_CH = 4,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int OUT_W  = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic              clr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              pd_in,
   output logic [OUT_W-1:0]  dac_out,
   output logic              pd_out
);
   if (!dacif_pkg::width_ok(DATA_W)) begin : g_bad_width
      $error("dacif_quad: DATA_W out of range");
   end
   if ((NUM_CH < 2) || ((1 << ADDR_W) != NUM_CH)) begin : g_bad_ch
      $error("dacif_quad: NUM_CH must be a power of two, at least 2");
   end

   logic              arst_n;
   logic              wr_rise;
   logic [NUM_CH-1:0] ch_wr_en;

   // power-on reset and clear share one asynchronous path
   assign arst_n = rst_n & clr_n;

   dacif_strobe i_strobe (
      .clk    (clk),
      .arst_n (arst_n),
      .wr_n   (wr_n),
      .rise   (wr_rise)
   );

   dacif_decode #(.NUM_CH(NUM_CH)) i_decode (
      .stb   (wr_rise),
      .cs_n  (cs_n),
      .addr  (addr),
      .wr_en (ch_wr_en)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dacif_channel #(.DATA_W(DATA_W)) i_chan (
         .clk    (clk),
         .arst_n (arst_n),
         .wr_en  (ch_wr_en[c]),
         .ld_n   (ld_n),
         .din    (data),
         .dout   (dac_out[c*DATA_W +: DATA_W])
      );
   end

   assign pd_out = pd_in;
endmodule

// File: rtl/dacif_quad_chk.sv
module dacif_quad_chk #(
   parameter int DATA_W = 10,
   parameter int NUM_CH = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cs_n,
   input logic                     ld_n,
   input logic                     clr_n,
   input logic [NUM_CH-1:0]        wr_en,
   input logic [NUM_CH*DATA_W-1:0] dac_out
);
   // R1
   reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> dac_out == '0);

   // R3
   no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> wr_en == '0);

   // R4
   one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R5
   load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      ld_n |=> $stable(dac_out));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> dac_out == '0);
endmodule

bind dacif_quad dacif_quad_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .ld_n    (ld_n),
   .clr_n   (clr_n),
   .wr_en   (ch_wr_en),
   .dac_out (dac_out)
);

// File: tb/test_dacif_quad.sv
module test_dacif_quad;
   localparam int PERIOD = 10;
   localparam int W = 10;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
   logic [1:0] addr = '0;
   logic [W-1:0] data = '0;
   logic pd_in = 1'b0;
   logic [N*W-1:0] dac_out;
   logic pd_out;

   int total = 0, bad = 0;
   logic [W-1:0] m_in [N];
   logic [W-1:0] m_dac [N];

   always #(PERIOD/2) clk = ~clk;

   dacif_quad i_dacif_quad (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
      .clr_n(clr_n), .addr(addr), .data(data), .pd_in(pd_in),
      .dac_out(dac_out), .pd_out(pd_out)
   );

   task automatic check_outs(input string req);
      for (int c = 0; c < N; c++) begin
         total++;
         if (dac_out[c*W +: W] !== m_dac[c]) begin
            bad++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, c, dac_out[c*W +: W], m_dac[c]);
         end
      end
   endtask

   task automatic model_load();
      for (int c = 0; c < N; c++) m_dac[c] = m_in[c];
   endtask

   task automatic model_zero();
      for (int c = 0; c < N; c++) begin m_in[c] = '0; m_dac[c] = '0; end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d, input logic sel_n);
      @(negedge clk); cs_n = sel_n; addr = a; data = d; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      if (!sel_n) begin
         m_in[a] = d;
         if (!ld_n) model_load();
      end
   endtask

   task automatic load_pulse();
      @(negedge clk); ld_n = 1'b0;
      @(negedge clk); ld_n = 1'b1;
      model_load();
   endtask

   task automatic t_reset();
      model_zero();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1 after reset");
      bus_write(2'd1, 10'h155, 1'b0);
      check_outs("R1 write without load");
   endtask

   task automatic t_write_load();
      bus_write(2'd0, 10'h011, 1'b0);
      bus_write(2'd1, 10'h222, 1'b0);
      bus_write(2'd2, 10'h3FF, 1'b0);
      bus_write(2'd3, 10'h0A5, 1'b0);
      repeat (2) @(negedge clk);
      check_outs("R5 hold while load high");
      load_pulse();
      check_outs("R2 R4 R5 load all");
      bus_write(2'd2, 10'h100, 1'b0);
      load_pulse();
      check_outs("R4 single channel");
   endtask

   task automatic t_no_select();
      bus_write(2'd1, 10'h3C3, 1'b1);
      load_pulse();
      check_outs("R3 cs_n high");
   endtask

   task automatic t_through();
      @(negedge clk); ld_n = 1'b0;
      bus_write(2'd3, 10'h2B4, 1'b0);
      check_outs("R6 write with load low");
      @(negedge clk); ld_n = 1'b1;
   endtask

   task automatic t_clear();
      @(negedge clk);
      #(PERIOD/4) clr_n = 1'b0;
      #1;
      model_zero();
      check_outs("R7 asynchronous clear");
      @(negedge clk); clr_n = 1'b1;
      load_pulse();
      check_outs("R7 staging cleared");
   endtask

   task automatic t_clear_priority();
      bus_write(2'd0, 10'h077, 1'b0);
      load_pulse();
      check_outs("R8 setup");
      @(negedge clk); cs_n = 1'b0; addr = 2'd1; data = 10'h1E1; wr_n = 1'b0; ld_n = 1'b0;
      @(negedge clk); wr_n = 1'b1; clr_n = 1'b0;
      @(negedge clk);
      model_zero();
      check_outs("R8 clear over write and load");
      cs_n = 1'b1; clr_n = 1'b1;
      @(negedge clk); ld_n = 1'b1;
      check_outs("R8 write lost");
   endtask

   task automatic t_power_down();
      bus_write(2'd2, 10'h2AA, 1'b0);
      load_pulse();
      @(negedge clk); pd_in = 1'b1;
      #1;
      total++;
      if (pd_out !== 1'b1) begin bad++; $display("FAIL R9 pd_out actual=%b expected=1", pd_out); end
      repeat (2) @(negedge clk);
      check_outs("R9 registers kept in power-down");
      pd_in = 1'b0;
      #1;
      total++;
      if (pd_out !== 1'b0) begin bad++; $display("FAIL R9 pd_out actual=%b expected=0", pd_out); end
   endtask

   initial begin
      t_reset();
      t_write_load();
      t_no_select();
      t_through();
      t_clear();
      t_clear_priority();
      t_power_down();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule